// File: doc/BRIEF.md
# Per-Block Search Filter for a Load/Store Queue Partition

This block sits beside one partition of an unordered load/store queue and decides, for each new load or store, whether an associative search of the partition's address and age CAMs is needed. Each in-flight instruction block owns one small filter, a plain bit vector. When a memory operation enters the partition, a hash of its address sets one bit in the filter that belongs to its block. A later operation queries all filters at once. If no live block has the hashed bit set, no earlier entry can share its address, and the CAM search is skipped.

The filters hold single bits and have no counters, so entries are never removed one at a time. A whole filter is wiped in one cycle when its block commits or is flushed. A live-block vector records which filter slots belong to blocks now in flight. A wiped slot plays no part in queries until a new block is allocated to it. The query path is combinational, so the answer is ready in the cycle the query is made.

Top module: `lsq_search_filter`

## Requirements
- R1: After reset no block slot is live and every query reports that no search is needed (`qry_search` = 0).
- R2: The filter index of an address is address bits [7:3]: addresses that differ only in bits [2:0] or above bit 7 map to the same filter bit.
- R3: An insert into a live block sets the bit at the hashed index in that block's filter. From the next cycle, a query whose index matches reports that a search is needed, and a query with a different index does not.
- R4: `qry_search` is combinational on the query inputs in the same cycle, and it is 0 whenever `qry_valid` is 0.
- R5: A commit of a block clears that block's filter and its live bit together, effective at the next clock edge.
- R6: A flush of a block clears that block's filter and its live bit together, effective at the next clock edge.
- R7: When an insert and a clear (commit or flush) name the same block in the same cycle, the clear wins and the inserted bit is not kept.
- R8: An insert that names a block slot that is not live at that clock edge is dropped. This includes a slot that is being allocated in the same cycle.
- R9: An allocation sets the slot's live bit. A slot that is allocated again after a clear starts with an empty filter. The live vector changes only on allocation, commit or flush.
- R10: A query ORs the hashed bit across live block slots only. A cleared slot never makes a query report a search.
- R11: A commit and a flush that name different blocks in the same cycle both take effect.
- R12: When an allocation and a clear name the same slot in the same cycle, the clear wins and the slot stays not live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate a block slot to a new in-flight block |
| alloc_blk | input | 3 | Slot being allocated |
| ins_valid | input | 1 | A memory operation entered the partition |
| ins_blk | input | 3 | Block slot of the inserted operation |
| ins_addr | input | 40 | Byte address of the inserted operation |
| qry_valid | input | 1 | Query request this cycle |
| qry_addr | input | 40 | Byte address being queried |
| qry_search | output | 1 | 1: an associative search is needed; 0: it can be skipped |
| commit_valid | input | 1 | A block commits |
| commit_blk | input | 3 | Slot of the committing block |
| flush_valid | input | 1 | A block is flushed |
| flush_blk | input | 3 | Slot of the flushed block |
| blk_live | output | 8 | Live-slot vector, bit b set when slot b holds an in-flight block |

## Verification
The bench builds the block with its default parameters: eight slots, 32-bit filters and a 40-bit address. With eight slots, a test can fill every slot and then clear one, so the OR across live slots is checked with both live and dead neighbours. With 32-bit filters, two addresses 256 bytes apart alias to the same bit, so an aliased pair is a true hit that the bench can predict. The same-cycle collisions of insert with clear, allocate with clear, and commit with flush are all driven on purpose.

// File: rtl/lsq_filt_pkg.sv
// Shared types for the per-block search filter.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package lsq_filt_pkg;

    // Action applied to one filter row at the next clock edge.
    typedef enum logic [1:0] {
        ROW_HOLD  = 2'd0,
        ROW_SET   = 2'd1,
        ROW_CLEAR = 2'd2
    } row_op_e;

    // Access granularity in address bits (8-byte words).
    localparam int unsigned WORD_LSB = 3;

endpackage

// File: rtl/lsq_filt_hash.sv
// Address hash: picks IDX_W address bits just above the access granularity.
// Assumes: ADDR_W >= GRAN_LSB + IDX_W.
module lsq_filt_hash #(
    parameter int unsigned ADDR_W   = 40,
    parameter int unsigned GRAN_LSB = 3,
    parameter int unsigned IDX_W    = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);

    // Slice the index field out of the address.
    always_comb begin
        idx = addr[GRAN_LSB +: IDX_W];
    end

endmodule

// File: rtl/lsq_filt_row.sv
// One filter row: a plain bit vector owned by one block slot.
// Supports set-one-bit and flash-clear; clear has priority by encoding.
// Assumes: FILT_BITS is a power of two equal to 2**IDX_W.
module lsq_filt_row
    import lsq_filt_pkg::*;
#(
    parameter int unsigned FILT_BITS = 32,
    parameter int unsigned IDX_W     = $clog2(FILT_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  row_op_e          op,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [IDX_W-1:0] qry_idx,
    output logic             qry_bit
);

    logic [FILT_BITS-1:0] bits_q;

    // Row state: reset empty, wiped on clear, one bit added on set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            unique case (op)
                ROW_CLEAR: bits_q <= '0;
                ROW_SET:   bits_q[set_idx] <= 1'b1;
                default:   bits_q <= bits_q;
            endcase
        end
    end

    // Read port for queries.
    always_comb begin
        qry_bit = bits_q[qry_idx];
    end

endmodule

// File: rtl/lsq_filt_live.sv
// Live-slot tracker: one bit per block slot, set on allocation,
// cleared on commit or flush. A clear beats an allocation of the same slot.
// Assumes: alloc_oh and clr_oh are decoded one-hot (or zero) by the caller.
module lsq_filt_live #(
    parameter int unsigned NUM_BLOCKS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_BLOCKS-1:0] alloc_oh,
    input  logic [NUM_BLOCKS-1:0] clr_oh,
    output logic [NUM_BLOCKS-1:0] live
);

    logic [NUM_BLOCKS-1:0] live_q;

    // Live vector update with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= '0;
        end else begin
            live_q <= (live_q | alloc_oh) & ~clr_oh;
        end
    end

    // Expose the state.
    always_comb begin
        live = live_q;
    end

endmodule

// File: rtl/lsq_search_filter.sv
// Per-block search filter for one load/store queue partition.
// One bit-vector filter per in-flight block slot; inserts set the hashed bit
// in the owning block's row, queries OR the hashed bit over live rows.
// Assumes: NUM_BLOCKS is a power of two; block ids come from the scheduler.
module lsq_search_filter
    import lsq_filt_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS = 8,
    parameter int unsigned FILT_BITS  = 32,
    parameter int unsigned ADDR_W     = 40,
    localparam int unsigned BID_W     = $clog2(NUM_BLOCKS),
    localparam int unsigned IDX_W     = $clog2(FILT_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_valid,
    input  logic [BID_W-1:0]      alloc_blk,
    input  logic                  ins_valid,
    input  logic [BID_W-1:0]      ins_blk,
    input  logic [ADDR_W-1:0]     ins_addr,
    input  logic                  qry_valid,
    input  logic [ADDR_W-1:0]     qry_addr,
    output logic                  qry_search,
    input  logic                  commit_valid,
    input  logic [BID_W-1:0]      commit_blk,
    input  logic                  flush_valid,
    input  logic [BID_W-1:0]      flush_blk,
    output logic [NUM_BLOCKS-1:0] blk_live
);

    logic [IDX_W-1:0]      ins_idx;
    logic [IDX_W-1:0]      qry_idx;
    logic [NUM_BLOCKS-1:0] alloc_oh;
    logic [NUM_BLOCKS-1:0] ins_oh;
    logic [NUM_BLOCKS-1:0] clr_oh;
    logic [NUM_BLOCKS-1:0] live;
    logic [NUM_BLOCKS-1:0] row_bit;
    logic [NUM_BLOCKS-1:0] row_hit;

    lsq_filt_hash #(
        .ADDR_W  (ADDR_W),
        .GRAN_LSB(WORD_LSB),
        .IDX_W   (IDX_W)
    ) ins_hash_i (
        .addr(ins_addr),
        .idx (ins_idx)
    );

    lsq_filt_hash #(
        .ADDR_W  (ADDR_W),
        .GRAN_LSB(WORD_LSB),
        .IDX_W   (IDX_W)
    ) qry_hash_i (
        .addr(qry_addr),
        .idx (qry_idx)
    );

    // Decode the event block ids into one-hot slot vectors.
    always_comb begin
        alloc_oh = '0;
        ins_oh   = '0;
        clr_oh   = '0;
        if (alloc_valid)  alloc_oh[alloc_blk] = 1'b1;
        if (ins_valid)    ins_oh[ins_blk]     = 1'b1;
        if (commit_valid) clr_oh[commit_blk]  = 1'b1;
        if (flush_valid)  clr_oh[flush_blk]   = 1'b1;
    end

    lsq_filt_live #(
        .NUM_BLOCKS(NUM_BLOCKS)
    ) live_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc_oh(alloc_oh),
        .clr_oh  (clr_oh),
        .live    (live)
    );

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_row
        row_op_e op;

        // Row action: clear first, then a set only into an already-live slot.
        always_comb begin
            if (clr_oh[b])                 op = ROW_CLEAR;
            else if (ins_oh[b] && live[b]) op = ROW_SET;
            else                           op = ROW_HOLD;
        end

        lsq_filt_row #(
            .FILT_BITS(FILT_BITS),
            .IDX_W    (IDX_W)
        ) row_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .op     (op),
            .set_idx(ins_idx),
            .qry_idx(qry_idx),
            .qry_bit(row_bit[b])
        );
    end

    // Query result: hashed bit in any live row.
    always_comb begin
        row_hit    = row_bit & live;
        qry_search = qry_valid && (|row_hit);
        blk_live   = live;
    end

endmodule

// File: rtl/lsq_search_filter_chk.sv
// Checker for lsq_search_filter: port-level properties of the live vector
// and the query output. Attached with the bind statement at the end.
module lsq_search_filter_chk #(
    parameter int unsigned NUM_BLOCKS = 8,
    localparam int unsigned BID_W     = $clog2(NUM_BLOCKS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  alloc_valid,
    input logic [BID_W-1:0]      alloc_blk,
    input logic                  commit_valid,
    input logic [BID_W-1:0]      commit_blk,
    input logic                  flush_valid,
    input logic [BID_W-1:0]      flush_blk,
    input logic                  qry_valid,
    input logic                  qry_search,
    input logic [NUM_BLOCKS-1:0] blk_live
);

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> (blk_live == '0));

    // R4
    idle_query_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !qry_valid |-> !qry_search);

    // R10
    dead_slots_no_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_live == '0) |-> !qry_search);

    // R5
    commit_kills_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> !blk_live[$past(commit_blk)]);

    // R6
    flush_kills_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> !blk_live[$past(flush_blk)]);

    // R9
    alloc_makes_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && !(commit_valid && commit_blk == alloc_blk)
                     && !(flush_valid && flush_blk == alloc_blk))
        |=> blk_live[$past(alloc_blk)]);

    // R9
    live_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_valid && !commit_valid && !flush_valid) |=> $stable(blk_live));

endmodule

bind lsq_search_filter lsq_search_filter_chk #(
    .NUM_BLOCKS(NUM_BLOCKS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_blk   (alloc_blk),
    .commit_valid(commit_valid),
    .commit_blk  (commit_blk),
    .flush_valid (flush_valid),
    .flush_blk   (flush_blk),
    .qry_valid   (qry_valid),
    .qry_search  (qry_search),
    .blk_live    (blk_live)
);

// File: tb/lsq_search_filter_tb_top.sv
// Directed bench for lsq_search_filter, one task per scenario.
module lsq_search_filter_tb_top;

    localparam int unsigned NB = 8;
    localparam int unsigned AW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [2:0]    alloc_blk = '0;
    logic          ins_valid = 1'b0;
    logic [2:0]    ins_blk = '0;
    logic [AW-1:0] ins_addr = '0;
    logic          qry_valid = 1'b0;
    logic [AW-1:0] qry_addr = '0;
    logic          qry_search;
    logic          commit_valid = 1'b0;
    logic [2:0]    commit_blk = '0;
    logic          flush_valid = 1'b0;
    logic [2:0]    flush_blk = '0;
    logic [NB-1:0] blk_live;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lsq_search_filter dut_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_blk(alloc_blk),
        .ins_valid(ins_valid), .ins_blk(ins_blk), .ins_addr(ins_addr),
        .qry_valid(qry_valid), .qry_addr(qry_addr), .qry_search(qry_search),
        .commit_valid(commit_valid), .commit_blk(commit_blk),
        .flush_valid(flush_valid), .flush_blk(flush_blk),
        .blk_live(blk_live)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Wait for the edge that applies the driven events, then drop them.
    task automatic apply();
        @(posedge clk);
        #1;
        alloc_valid = 1'b0; ins_valid = 1'b0;
        commit_valid = 1'b0; flush_valid = 1'b0;
    endtask

    task automatic alloc(input logic [2:0] b);
        @(negedge clk); alloc_valid = 1'b1; alloc_blk = b; apply();
    endtask

    task automatic insert(input logic [2:0] b, input logic [AW-1:0] a);
        @(negedge clk); ins_valid = 1'b1; ins_blk = b; ins_addr = a; apply();
    endtask

    task automatic commit(input logic [2:0] b);
        @(negedge clk); commit_valid = 1'b1; commit_blk = b; apply();
    endtask

    // Combinational query, sampled 1 ns after the inputs settle.
    task automatic query(input string req, input logic [AW-1:0] a, input logic exp);
        qry_valid = 1'b1; qry_addr = a;
        #1;
        check(req, $sformatf("query %0h", a), {63'd0, qry_search}, {63'd0, exp});
        qry_valid = 1'b0;
    endtask

    task automatic t_reset();
        // R1: nothing live, no search
        check("R1", "live after reset", {56'd0, blk_live}, 64'd0);
        query("R1", 40'h1238, 1'b0);
    endtask

    task automatic t_insert_hit();
        alloc(3'd0);
        insert(3'd0, 40'h1238);                // index 7
        query("R3", 40'h1238, 1'b1);
        query("R3", 40'h1240, 1'b0);           // index 8
        query("R2", 40'h123F, 1'b1);           // same word, bits [2:0] differ
        query("R2", 40'h0538, 1'b1);           // alias: bits above 7 differ
        query("R2", 40'h1230, 1'b0);           // index 6
        // R4: query disabled gives 0 even on a hit address
        qry_valid = 1'b0; qry_addr = 40'h1238; #1;
        check("R4", "idle query", {63'd0, qry_search}, 64'd0);
    endtask

    task automatic t_commit_clear();
        commit(3'd0);
        check("R5", "live after commit", {63'd0, blk_live[0]}, 64'd0);
        query("R5", 40'h1238, 1'b0);
        alloc(3'd0);
        check("R9", "live after realloc", {63'd0, blk_live[0]}, 64'd1);
        query("R9", 40'h1238, 1'b0);           // fresh filter empty
        commit(3'd0);
    endtask

    task automatic t_flush_clear();
        alloc(3'd3);
        insert(3'd3, 40'h40);                  // index 8
        query("R3", 40'h40, 1'b1);
        @(negedge clk); flush_valid = 1'b1; flush_blk = 3'd3; apply();
        check("R6", "live after flush", {63'd0, blk_live[3]}, 64'd0);
        query("R6", 40'h40, 1'b0);
        alloc(3'd3);
        query("R6", 40'h40, 1'b0);             // filter was wiped
        commit(3'd3);
    endtask

    task automatic t_insert_vs_clear();
        alloc(3'd2);
        @(negedge clk);
        ins_valid = 1'b1; ins_blk = 3'd2; ins_addr = 40'h80;   // index 16
        commit_valid = 1'b1; commit_blk = 3'd2;
        apply();
        alloc(3'd2);
        query("R7", 40'h80, 1'b0);
        commit(3'd2);
    endtask

    task automatic t_dead_insert();
        insert(3'd5, 40'hC8);                  // slot 5 not live
        alloc(3'd5);
        query("R8", 40'hC8, 1'b0);
        // insert in the same cycle as allocation is also dropped
        commit(3'd5);
        @(negedge clk);
        alloc_valid = 1'b1; alloc_blk = 3'd5;
        ins_valid = 1'b1; ins_blk = 3'd5; ins_addr = 40'hC8;
        apply();
        query("R8", 40'hC8, 1'b0);
        commit(3'd5);
    endtask

    task automatic t_two_clears();
        alloc(3'd1);
        alloc(3'd4);
        insert(3'd1, 40'h10);                  // index 2
        insert(3'd4, 40'h18);                  // index 3
        query("R10", 40'h10, 1'b1);
        query("R10", 40'h18, 1'b1);
        query("R10", 40'h20, 1'b0);
        @(negedge clk);
        commit_valid = 1'b1; commit_blk = 3'd1;
        flush_valid = 1'b1; flush_blk = 3'd4;
        apply();
        check("R11", "live after dual clear", {56'd0, blk_live}, 64'd0);
        query("R11", 40'h10, 1'b0);
        query("R11", 40'h18, 1'b0);
    endtask

    task automatic t_alloc_vs_clear();
        @(negedge clk);
        alloc_valid = 1'b1; alloc_blk = 3'd6;
        commit_valid = 1'b1; commit_blk = 3'd6;
        apply();
        check("R12", "slot after alloc+clear", {63'd0, blk_live[6]}, 64'd0);
    endtask

    task automatic t_all_slots();
        for (int b = 0; b < NB; b++) alloc(3'(b));
        check("R9", "all live", {56'd0, blk_live}, 64'hFF);
        for (int b = 0; b < NB; b++) insert(3'(b), 40'(b * 8));
        for (int b = 0; b < NB; b++) query("R3", 40'(b * 8), 1'b1);
        commit(3'd7);
        query("R10", 40'h38, 1'b0);            // only slot 7 held index 7
        query("R10", 40'h30, 1'b1);
        check("R9", "live after one commit", {56'd0, blk_live}, 64'h7F);
    endtask

    initial begin : watchdog
        #(5 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_insert_hit();
        t_commit_clear();
        t_flush_clear();
        t_insert_vs_clear();
        t_dead_insert();
        t_two_clears();
        t_alloc_vs_clear();
        t_all_slots();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule